// File: doc/BRIEF.md
# Programmable Bit-Clock Divider with Deferred Reload

This block derives a serial bit clock from a down-counting reload counter. A single 16-bit configuration write selects the counting source and supplies a 15-bit reload value. The source is either every cycle of the system clock or the rising edges of an external clock pin. The counter runs from the reload value down to zero and then reloads. The divided clock `sclk` is high for the upper part of each count cycle. A one-cycle `tick` marks every reload caused by expiry.

If the counter is already running, a new reload value is held back until the present count cycle expires. The programmable clear strobe makes a held-back value take effect at once. A reload value of zero stops the generator. To move a running generator onto the external source, software writes zero, applies a clear, and then writes the select bit with the wanted value. The block contains no shift logic. It is meant to feed the bit-timing logic of an asynchronous serial port.

Top module: `baud_reload_gen`

## Requirements
- R1: During reset and in the first cycle after reset, `sclk` and `tick` are 0 and the generator is stopped. It has no reload value, so it stays stopped until a write arrives.
- R2: In a write, `cfg_wdata[15]` selects the source (0 system clock, 1 external pin) and `cfg_wdata[14:0]` is the reload value R. A write of a nonzero R to a stopped generator loads R at once, so `sclk` is 1 in the cycle after the write. Nonzero R below 4 is never written.
- R3: In system-clock mode a running generator repeats every R+1 cycles. `tick` is 1 for exactly one cycle at each expiry-driven reload, and that cycle is the first high cycle of `sclk`.
- R4: Within each period `sclk` is high for R − floor(R/2) counts and low for floor(R/2)+1 counts. For odd R the two phases are equal. For even R the low phase is one count longer.
- R5: A write made while the generator is running changes the reload value only at the next expiry. The current count cycle completes with the old value, and the select bit of the write applies from the next cycle.
- R6: A `pclr` pulse loads the most recently written reload value immediately, or the value written in the same cycle. `sclk` is then 1 and `tick` is 0 in the next cycle, and the following tick arrives R+1 counts later.
- R7: When R is 0, whether reached by expiry or by a clear, the counter stops, `sclk` stays 0 and `tick` stays 0.
- R8: In external mode the counter advances by one count per rising edge of `ext_clk`. The count lands on the third system-clock edge that samples the pin high. Steady levels and falling edges cause no count.
- R9: In system-clock mode `ext_clk` has no effect, and writing the select bit back to 0 restores counting on every system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Bit 15 source select, bits 14:0 reload value |
| pclr | input | 1 | Programmable clear: apply the stored reload value now |
| ext_clk | input | 1 | External count clock, asynchronous to `clk` |
| sclk | output | 1 | Divided serial bit clock (registered) |
| tick | output | 1 | One-cycle pulse at each expiry reload (registered) |

## Verification
The checker assumes that every nonzero reload value written is at least 4. Only with such values are ticks at least five counts apart and the high phase non-empty. An immediate check flags any write that breaks this. Both the directed sequences and the random phase draw reload values that are either zero or 4 and above. The external pin is treated as asynchronous but slow enough that each level lasts at least one system clock. The bench meets this by changing `ext_clk` only on falling edges of the system clock.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned RELOAD_W_DEF    = 15;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    SRC_BUS = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/baud_ext_edge.sv
module baud_ext_edge #(
  parameter int unsigned STAGES = baud_gen_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  // stage 0 samples the pin, stages up to STAGES-1 resolve it,
  // the last stage keeps the previous resolved level for edge detection
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe_q[g] <= 1'b0;
          else     pipe_q[g] <= ext_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe_q[g] <= 1'b0;
          else     pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_gen_pkg::*;
#(
  parameter int unsigned RELOAD_W = RELOAD_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [RELOAD_W:0]   cfg_wdata,
  output logic [RELOAD_W-1:0] pending,
  output clk_src_e            src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      src     <= SRC_BUS;
    end else if (cfg_we) begin
      pending <= cfg_wdata[RELOAD_W-1:0];
      src     <= clk_src_e'(cfg_wdata[RELOAD_W]);
    end
  end
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int unsigned RELOAD_W = baud_gen_pkg::RELOAD_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic                force_load,
  input  logic [RELOAD_W-1:0] force_val,
  input  logic [RELOAD_W-1:0] pending,
  output logic [RELOAD_W-1:0] cnt_q,
  output logic [RELOAD_W-1:0] active_q,
  output logic                sclk,
  output logic                tick
);
  localparam logic [RELOAD_W-1:0] ONE = {{(RELOAD_W-1){1'b0}}, 1'b1};

  logic [RELOAD_W-1:0] cnt_n;
  logic [RELOAD_W-1:0] act_n;
  logic                tick_n;
  logic                sclk_n;
  logic                running;

  assign running = (active_q != '0);

  always_comb begin
    cnt_n  = cnt_q;
    act_n  = active_q;
    tick_n = 1'b0;
    if (force_load) begin
      cnt_n = force_val;
      act_n = force_val;
    end else if (running && step) begin
      if (cnt_q == '0) begin
        cnt_n  = pending;
        act_n  = pending;
        tick_n = (pending != '0);
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
    sclk_n = (act_n != '0) && (cnt_n > (act_n >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= '0;
      sclk     <= 1'b0;
      tick     <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      active_q <= act_n;
      sclk     <= sclk_n;
      tick     <= tick_n;
    end
  end
endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned RELOAD_W    = RELOAD_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RELOAD_W:0] cfg_wdata,
  input  logic              pclr,
  input  logic              ext_clk,
  output logic              sclk,
  output logic              tick
);
  logic [RELOAD_W-1:0] pending_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic [RELOAD_W-1:0] active_q;
  clk_src_e            src_q;
  logic                ext_rise;
  logic                step;
  logic                force_load;
  logic [RELOAD_W-1:0] force_val;

  baud_cfg_reg #(.RELOAD_W(RELOAD_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .pending   (pending_q),
    .src       (src_q)
  );

  baud_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .ext_in (ext_clk),
    .rise   (ext_rise)
  );

  assign step       = (src_q == SRC_EXT) ? ext_rise : 1'b1;
  assign force_load = pclr | (cfg_we & (active_q == '0));
  assign force_val  = cfg_we ? cfg_wdata[RELOAD_W-1:0] : pending_q;

  baud_down_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .force_load (force_load),
    .force_val  (force_val),
    .pending    (pending_q),
    .cnt_q      (cnt_q),
    .active_q   (active_q),
    .sclk       (sclk),
    .tick       (tick)
  );
endmodule

// File: rtl/baud_reload_gen_chk.sv
module baud_reload_gen_chk #(
  parameter int unsigned RELOAD_W = baud_gen_pkg::RELOAD_W_DEF
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [RELOAD_W:0]   cfg_wdata,
  input logic                pclr,
  input logic                sclk,
  input logic                tick,
  input logic [RELOAD_W-1:0] cnt,
  input logic [RELOAD_W-1:0] active,
  input logic [RELOAD_W-1:0] pending,
  input logic                sel_ext,
  input logic                ext_rise
);
  localparam logic [RELOAD_W-1:0] MIN_RELOAD = 4;

  always @(posedge clk) begin
    if (!rst && cfg_we && cfg_wdata[RELOAD_W-1:0] != '0)
      a_r2_min_reload: assert (cfg_wdata[RELOAD_W-1:0] >= MIN_RELOAD);
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sclk && !tick));

  a_r2_start_now: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !pclr && active == '0 && cfg_wdata[RELOAD_W-1:0] != '0)
    |=> (sclk && cnt == $past(cfg_wdata[RELOAD_W-1:0])));

  a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  a_r3_tick_on_rise: assert property (@(posedge clk) disable iff (rst)
    tick |-> $rose(sclk));

  a_r5_deferred: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !pclr && active != '0 && cnt != '0)
    |=> (active == $past(active)));

  a_r6_clear_load: assert property (@(posedge clk) disable iff (rst)
    (pclr && !cfg_we) |=> (cnt == $past(pending) && !tick));

  a_r7_stopped: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |-> (!sclk && !tick));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (sel_ext && !ext_rise && !cfg_we && !pclr) |=> ($stable(cnt) && !tick));
endmodule

bind baud_reload_gen baud_reload_gen_chk #(.RELOAD_W(RELOAD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .pclr      (pclr),
  .sclk      (sclk),
  .tick      (tick),
  .cnt       (cnt_q),
  .active    (active_q),
  .pending   (pending_q),
  .sel_ext   (src_q == baud_gen_pkg::SRC_EXT),
  .ext_rise  (ext_rise)
);

// File: tb/test_baud_reload_gen.sv
module test_baud_reload_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        pclr = 1'b0;
  logic        ext_clk = 1'b0;
  logic        sclk;
  logic        tick;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_reload_gen i_baud_reload_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pclr(pclr), .ext_clk(ext_clk), .sclk(sclk), .tick(tick)
  );

  // reference model built from the requirements
  logic [14:0] m_cnt, m_act, m_pend;
  logic m_sel, m_sclk, m_tick, m_e0, m_e1, m_e2;

  always @(posedge clk) begin
    logic rise, stp, frc;
    logic [14:0] fval;
    if (rst) begin
      m_cnt = '0; m_act = '0; m_pend = '0; m_sel = 0;
      m_sclk = 0; m_tick = 0; m_e0 = 0; m_e1 = 0; m_e2 = 0;
    end else begin
      rise = m_e1 & ~m_e2;                        // R8: third edge
      stp  = m_sel ? rise : 1'b1;                 // R9
      frc  = pclr | (cfg_we & (m_act == '0));     // R2, R6
      fval = cfg_we ? cfg_wdata[14:0] : m_pend;
      m_tick = 0;
      if (frc) begin
        m_act = fval; m_cnt = fval;
      end else if (m_act != '0 && stp) begin
        if (m_cnt == '0) begin                    // R5: deferred value
          m_act = m_pend; m_cnt = m_pend; m_tick = (m_pend != '0);
        end else m_cnt = m_cnt - 15'd1;
      end
      if (cfg_we) begin m_pend = cfg_wdata[14:0]; m_sel = cfg_wdata[15]; end
      m_e2 = m_e1; m_e1 = m_e0; m_e0 = ext_clk;
      m_sclk = (m_act != '0) && (m_cnt > (m_act >> 1));   // R4
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (sclk !== m_sclk) begin
        fails++; $display("FAIL R4 sclk model at %0t: actual %b expected %b", $time, sclk, m_sclk);
      end
      if (tick !== m_tick) begin
        fails++; $display("FAIL R3 tick model at %0t: actual %b expected %b", $time, tick, m_tick);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++; $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wait_tick();
    int g = 0;
    do begin @(negedge clk); cfg_we = 0; pclr = 0; g++; end while (!tick && g < 5000);
  endtask

  // starts at a negedge where tick is high; ends at the next such negedge
  task automatic measure(output int hi, output int lo);
    int g = 0;
    hi = 1; lo = 0;
    forever begin
      @(negedge clk); cfg_we = 0; pclr = 0; g++;
      if (tick || g > 5000) break;
      if (sclk) hi++; else lo++;
    end
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1; repeat (3) @(negedge clk);
      ext_clk = 0; repeat (3) @(negedge clk);
    end
  endtask

  int hi, lo, n, tk, lows;

  always @(negedge clk) if (!rst && tick) tk++;

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 sclk after reset", sclk, 0);
    check("R1 tick after reset", tick, 0);
    repeat (10) @(negedge clk);
    check("R1 still stopped", sclk, 0);

    write_cfg(16'h0005);
    check("R2 immediate start", sclk, 1);
    wait_tick();
    measure(hi, lo);
    check("R3 period R=5", hi + lo, 6);
    check("R4 odd high", hi, 3);
    check("R4 odd low", lo, 3);

    cfg_we = 1; cfg_wdata = 16'h0004;   // issued at a tick cycle
    measure(hi, lo);
    check("R5 old period kept", hi + lo, 6);
    measure(hi, lo);
    check("R5 new period", hi + lo, 5);
    check("R4 even high", hi, 2);
    check("R4 even low", lo, 3);

    write_cfg(16'h000B);
    repeat (2) @(negedge clk);
    pclr = 1; @(negedge clk); pclr = 0;
    check("R6 sclk after clear", sclk, 1);
    check("R6 no tick at clear", tick, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    check("R6 first period after clear", n, 12);

    write_cfg(16'h0000);
    repeat (40) @(negedge clk);
    tk = 0; lows = 0;
    repeat (30) begin @(negedge clk); if (!sclk) lows++; end
    check("R7 no ticks when stopped", tk, 0);
    check("R7 sclk held low", lows, 30);

    write_cfg(16'h8004);
    check("R8 start in ext mode", sclk, 1);
    tk = 0; lows = 0;
    repeat (30) begin @(negedge clk); if (!sclk) lows++; end
    check("R8 no count without edges", tk, 0);
    check("R8 sclk held", lows, 0);
    tk = 0;
    ext_pulses(25);
    check("R8 ticks per 25 edges", tk, 5);

    write_cfg(16'h0004);
    wait_tick();
    measure(hi, lo);
    check("R9 internal period restored", hi + lo, 5);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      cfg_we = 0; pclr = 0;
      if ($urandom_range(99) < 3) begin
        cfg_we = 1;
        cfg_wdata[14:0] = ($urandom_range(7) == 0) ? 15'd0 : 15'($urandom_range(20, 4));
        cfg_wdata[15] = ($urandom_range(3) == 0);
      end
      if ($urandom_range(99) < 1) pclr = 1;
      if ($urandom_range(2) == 0) ext_clk = ~ext_clk;
    end
    @(negedge clk); cfg_we = 0; pclr = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule